// File: doc/BRIEF.md
# Error-Correcting Line Framer with Serial Handshake

The block turns a byte stream held in an external transmission buffer into a serial line stream protected by a BCH(511,493) code. The stream is cut into 512-bit frames. Each frame opens with one bit of a slow multiframe alignment pattern. A fill indicator follows, then 492 payload bits, then 18 parity bits computed over the fill indicator and the payload. The buffer is read as a first-word-fall-through queue: the head byte is always visible on `rd_data`, its occupancy is given on `buf_level`, and `rd_req` removes the head byte in the cycle it is high.

When the buffer cannot supply a whole payload at the start of a frame, or when the host asks for it, the frame is sent stuffed. A stuffed frame carries an all-ones payload and consumes no buffer data. A single pulse on `stuff_o` marks each stuffed frame so that an external counter can track them. A test mode turns framing off and sends the buffer bytes raw.

The line side works like a simple X.21-style transmitter. `bit_en` is a one-cycle strobe standing for each falling edge of the line clock, and every output bit is launched on that strobe so the receiver can sample it on the rising edge. `val_n` is held high from reset until the receiver reports that it is ready. Tying `cts_n` low and `rdy` high gives a plain serial link.

Top module: `fec_framer`

## Requirements
- R1: After reset `val_n` = 1, `td` = 1, `stuff_o` = 0 and `rd_req` = 0.
- R2: `val_n` stays high, and `td` stays 1, until a `bit_en` strobe sees `cts_n` = 0 and `rdy` = 1. That strobe drives `val_n` low, which it then stays until reset. The first line bit goes out on the following strobe.
- R3: With `frame_en` = 1 each frame is 512 bits in this order: an alignment bit, a fill bit (1 = data frame, 0 = stuffed frame), 492 payload bits and 18 parity bits. Payload bits are buffer bytes sent MSB first. The bits carry on across data frames with none lost or repeated, and a byte is read only when its first bit is sent.
- R4: A frame is stuffed when, at its first bit, `buf_level` < 62 bytes. Its payload is then all ones and it reads no bytes from the buffer.
- R5: The 18 parity bits are the remainder of the fill bit and the payload (taken as a polynomial, earliest bit highest) times x^18, divided by x^18+x^15+x^12+x^10+x^8+x^7+x^6+x^3+1. Every 511 bits after the alignment bit therefore form a codeword that this polynomial divides.
- R6: The alignment bits of successive frames follow the pattern 0,0,0,1,1,0,1,1 and then repeat. The first frame after reset sends the first entry.
- R7: `stuff_o` is high for exactly one bit period, namely the alignment bit of each stuffed frame, and low in every other bit period.
- R8: `force_stuff` is sampled only at the first bit of each frame. Raising it mid-frame stuffs the next frame, not the current one. Clearing it during a forced stuffed frame leaves that frame stuffed, and the next frame then follows R4.
- R9: With `frame_en` = 0 the buffer bytes are sent back to back, MSB first, with no alignment, fill or parity bits. When a new byte is due and the buffer is empty a 1 is sent, and `stuff_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_en | input | 1 | 1 = framed output, 0 = raw test mode |
| force_stuff | input | 1 | Host request to stuff frames |
| bit_en | input | 1 | One-cycle strobe per falling line-clock edge |
| cts_n | input | 1 | Receiver clear-to-send, active low |
| rdy | input | 1 | Receiver ready, active high |
| buf_level | input | LVL_W | Bytes held in the transmission buffer |
| rd_data | input | 8 | Head byte of the transmission buffer |
| rd_req | output | 1 | Removes the head byte this cycle |
| val_n | output | 1 | Transmitter valid, active low |
| td | output | 1 | Serial line data |
| stuff_o | output | 1 | One-bit pulse per stuffed frame |

## Verification
Every line-side result is due at the clock edge where `bit_en` is high. `td`, `val_n` and `stuff_o` are registered there, so the bench raises the strobe for a single cycle and reads the outputs at the next falling clock edge. `rd_req` is combinational within the strobe cycle, so the bench's buffer model pops on that same edge. The stuffing decision is taken from `buf_level` and `force_stuff` as they stand before the first strobe of a frame, and the bench predicts the stuffing from exactly those values, so level changes and force toggles made mid-frame fall on the intended side of that decision.

// File: rtl/fec_framer.sv
module fec_framer #(
  parameter int LVL_W      = 16,
  parameter int FRAME_BITS = 512,
  parameter int PAY_BITS   = 492,
  parameter int PAR_BITS   = 18,
  parameter logic [PAR_BITS-1:0] GEN = 18'h095C9,
  parameter logic [7:0] ALIGN = 8'b0001_1011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_en,
  input  logic             force_stuff,
  input  logic             bit_en,
  input  logic             cts_n,
  input  logic             rdy,
  input  logic [LVL_W-1:0] buf_level,
  input  logic [7:0]       rd_data,
  output logic             rd_req,
  output logic             val_n,
  output logic             td,
  output logic             stuff_o
);
  localparam int POS_W     = $clog2(FRAME_BITS);
  localparam int PAY_BYTES = (PAY_BITS + 7) / 8;
  localparam logic [POS_W-1:0] P_FILL = POS_W'(1);
  localparam logic [POS_W-1:0] P_PAY0 = POS_W'(2);
  localparam logic [POS_W-1:0] P_PAYN = POS_W'(1 + PAY_BITS);
  localparam logic [POS_W-1:0] P_LAST = POS_W'(FRAME_BITS - 1);
  localparam logic [LVL_W-1:0] NEED_L = LVL_W'(PAY_BYTES);

  logic [POS_W-1:0]    pos;
  logic [2:0]          align_idx;
  logic [2:0]          cnt;
  logic [7:0]          sh;
  logic [PAR_BITS-1:0] par;
  logic                stuffed_q;
  logic                nxt;

  wire run       = bit_en && !val_n;
  wire stuff_now = force_stuff || (buf_level < NEED_L);
  wire in_pay    = frame_en ? (pos >= P_PAY0 && pos <= P_PAYN && !stuffed_q) : 1'b1;
  wire buf_empty = (buf_level == '0);
  wire adv       = run && in_pay && (cnt != 3'd0 || frame_en || !buf_empty);
  wire data_bit  = (cnt == 3'd0) ? rd_data[7] : sh[7];

  assign rd_req = adv && (cnt == 3'd0);

  always_comb begin
    if (!frame_en)             nxt = (cnt == 3'd0 && buf_empty) ? 1'b1 : data_bit;
    else if (pos == '0)        nxt = ALIGN[3'd7 - align_idx];
    else if (pos == P_FILL)    nxt = !stuffed_q;
    else if (pos <= P_PAYN)    nxt = stuffed_q ? 1'b1 : data_bit;
    else                       nxt = par[PAR_BITS-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_n     <= 1'b1;
      td        <= 1'b1;
      stuff_o   <= 1'b0;
      pos       <= '0;
      align_idx <= '0;
      cnt       <= '0;
      sh        <= '0;
      par       <= '0;
      stuffed_q <= 1'b0;
    end else begin
      if (bit_en && val_n && !cts_n && rdy) val_n <= 1'b0;
      if (bit_en) stuff_o <= run && frame_en && pos == '0 && stuff_now;
      if (run) td <= nxt;
      if (adv) begin
        if (cnt == 3'd0) begin
          sh  <= {rd_data[6:0], 1'b0};
          cnt <= 3'd7;
        end else begin
          sh  <= {sh[6:0], 1'b0};
          cnt <= cnt - 3'd1;
        end
      end
      if (!frame_en) pos <= '0;
      else if (run) begin
        if (pos == '0) begin
          stuffed_q <= stuff_now;
          par       <= '0;
        end else if (pos <= P_PAYN)
          par <= {par[PAR_BITS-2:0], 1'b0} ^ ((nxt ^ par[PAR_BITS-1]) ? GEN : '0);
        else
          par <= {par[PAR_BITS-2:0], 1'b0};
        if (pos == P_LAST) begin
          pos       <= '0;
          align_idx <= align_idx + 3'd1;
        end else pos <= pos + POS_W'(1);
      end
    end
  end

  AST_VAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !val_n |=> !val_n); // R2
  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) val_n |-> (td && !stuff_o && !rd_req)); // R2
  AST_READ_GUARD: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> (bit_en && !buf_empty)); // R3
  AST_STUFF_NO_READ: assert property (@(posedge clk) disable iff (!rst_n) (frame_en && stuffed_q && pos >= P_FILL) |-> !rd_req); // R4
  AST_STUFF_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n) (stuff_o && bit_en) |=> !stuff_o); // R7
  AST_RAW_NO_STUFF: assert property (@(posedge clk) disable iff (!rst_n) !frame_en |=> !stuff_o || !$past(bit_en)); // R9
endmodule

// File: tb/test_fec_framer.sv
module test_fec_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_en = 1'b1, force_stuff = 1'b0, bit_en = 1'b0, cts_n = 1'b1, rdy = 1'b0;
  logic [15:0] buf_level;
  logic [7:0]  rd_data;
  logic rd_req, val_n, td, stuff_o;

  logic [7:0] mem [0:1023];
  int hd, tl;
  int checks = 0, failures = 0;
  int exp_bits = 0, fcount = 0;
  logic got [0:511];
  logic stf [0:511];
  logic cw  [0:510];
  localparam logic [7:0] PAT = 8'b0001_1011;

  assign buf_level = 16'(tl - hd);
  assign rd_data   = mem[hd[9:0]];

  fec_framer i_fec_framer (.clk(clk), .rst_n(rst_n), .frame_en(frame_en), .force_stuff(force_stuff),
    .bit_en(bit_en), .cts_n(cts_n), .rdy(rdy), .buf_level(buf_level), .rd_data(rd_data),
    .rd_req(rd_req), .val_n(val_n), .td(td), .stuff_o(stuff_o));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) hd <= 0;
    else if (rd_req) hd <= hd + 1;
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
  endtask

  task automatic push(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      mem[tl[9:0]] = 8'((tl * 37 + seed * 11 + 5) ^ (tl >> 2));
      tl = tl + 1;
    end
  endtask

  function automatic logic sbit(input int idx);
    return mem[idx / 8][7 - (idx % 8)];
  endfunction

  task automatic frame_check(input int chg_at, input logic chg_val);
    int lvl, bad, offs[9], stbad, popped_before;
    logic es;
    offs = '{0, 3, 6, 8, 10, 11, 12, 15, 18};
    popped_before = (exp_bits + 7) / 8;
    lvl = tl - popped_before;
    es = force_stuff || (lvl < 62);
    for (int i = 0; i < 512; i++) begin
      if (i == chg_at) force_stuff = chg_val;
      tick();
      got[i] = td;
      stf[i] = stuff_o;
    end
    chk($sformatf("R6 align bit frame %0d", fcount), int'(got[0]), int'(PAT[7 - (fcount % 8)]));
    chk($sformatf("R3 R4 R8 fill bit frame %0d", fcount), int'(got[1]), int'(!es));
    bad = 0;
    for (int i = 0; i < 492; i++)
      if (got[2 + i] !== (es ? 1'b1 : sbit(exp_bits + i))) bad++;
    chk($sformatf("R3 R4 payload mismatches frame %0d", fcount), bad, 0);
    for (int i = 0; i < 511; i++) cw[i] = got[i + 1];
    for (int i = 0; i < 493; i++)
      if (cw[i]) for (int k = 0; k < 9; k++) cw[i + offs[k]] = cw[i + offs[k]] ^ 1'b1;
    bad = 0;
    for (int i = 493; i < 511; i++) if (cw[i]) bad++;
    chk($sformatf("R5 syndrome bits frame %0d", fcount), bad, 0);
    stbad = 0;
    for (int i = 1; i < 512; i++) if (stf[i]) stbad++;
    chk($sformatf("R7 stuff pulse first bit frame %0d", fcount), int'(stf[0]), int'(es));
    chk($sformatf("R7 stuff high elsewhere frame %0d", fcount), stbad, 0);
    if (!es) exp_bits += 492;
    chk($sformatf("R3 R4 bytes read by frame %0d", fcount), hd, (exp_bits + 7) / 8);
    fcount++;
  endtask

  initial begin
    tl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 val_n", int'(val_n), 1);
    chk("R1 td", int'(td), 1);
    chk("R1 stuff_o", int'(stuff_o), 0);
    chk("R1 rd_req", int'(rd_req), 0);
    push(61, 1);
    cts_n = 1'b1; rdy = 1'b1;
    repeat (3) tick();
    chk("R2 val_n cts high", int'(val_n), 1);
    chk("R2 td idle", int'(td), 1);
    cts_n = 1'b0; rdy = 1'b0;
    tick();
    chk("R2 val_n rdy low", int'(val_n), 1);
    cts_n = 1'b0; rdy = 1'b1;
    tick();
    chk("R2 val_n ready", int'(val_n), 0);
    chk("R2 td before first bit", int'(td), 1);
    chk("R2 no read yet", hd, 0);
    frame_check(-1, 1'b0);
    push(130, 2);
    frame_check(-1, 1'b0);
    frame_check(100, 1'b1);
    frame_check(200, 1'b0);
    frame_check(-1, 1'b0);
    frame_check(-1, 1'b0);
    push(100, 3);
    frame_check(-1, 1'b0);
    frame_check(-1, 1'b0);
    cts_n = 1'b1; rdy = 1'b0;
    tick();
    chk("R2 val_n sticky", int'(val_n), 0);

    frame_en = 1'b0;
    rst_n = 1'b0;
    tl = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    push(3, 4);
    cts_n = 1'b0; rdy = 1'b1;
    tick();
    begin
      int bad, sb;
      bad = 0; sb = 0;
      for (int i = 0; i < 32; i++) begin
        tick();
        if (td !== (i < 24 ? sbit(i) : 1'b1)) bad++;
        if (stuff_o) sb++;
      end
      chk("R9 raw bit mismatches", bad, 0);
      chk("R9 raw stuff pulses", sb, 0);
      chk("R9 raw bytes read", hd, 3);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule